// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the station side of a two-wire PHY management link. Software first sets a management-enable bit in a control register. It then writes one 32-bit maintenance word whose fields already match the serial frame: start, opcode, PHY address, register address, turnaround and a 16-bit data field. That single write launches the whole transaction. The block sends a 32-bit preamble of ones and then the 32 frame bits on the data pin, timed against a divided management clock.

For a read opcode, the block releases the data pin from the turnaround bits onward. It samples the 16 bits the PHY returns and shifts them into the low half of the maintenance word, where software reads them back. An idle flag in a status register shows whether a frame is in flight, so software polls it before it issues the next access. The data pin is split into output, output-enable and input for an external tri-state pad.

Top module: `mdio_master`

## Requirements
- R1: After reset the idle flag is 1, MDC is low, the output enable is 0, and the control and maintenance registers read as zero.
- R2: A write to the maintenance register (register select 2) while the enable bit is set and no frame is in flight starts a frame, and the idle flag (status register, select 1, bit 2) reads 0 from the next clock.
- R3: On the data pin, each frame is 32 ones followed by maintenance bits 31 down to 0, one bit per MDC period. The driven value changes only when MDC falls.
- R4: One MDC period is CLK_DIV system clocks, with equal high and low halves. MDC stays low whenever no frame is in flight.
- R5: When bits 29:28 hold 2'b10 (read), the output enable is 0 from frame bit 17 (the first turnaround bit) to the end. The input is sampled on the 16 rising MDC edges of frame bits 15..0 and lands MSB-first in maintenance bits 15:0, while bits 31:16 keep the written value.
- R6: For any other opcode, such as 2'b01 (write), the output enable stays 1 for all 64 bits. The register keeps the written word, and the idle flag returns to 1 exactly 64*CLK_DIV clocks after the frame started.
- R7: A write to the maintenance register while a frame is in flight changes neither the register nor the frame on the pin.
- R8: The enable bit is bit 4 of the control register (select 0). While it is 0, maintenance writes are ignored and start nothing. Clearing it mid-frame stops the frame, releases the pin and sets the idle flag.
- R9: The status register reads 0 except for the idle flag at bit 2. The control register reads back the enable at bit 4 and 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 maintenance |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data pin output value |
| mdio_oe | output | 1 | Data pin output enable |
| mdio_i | input | 1 | Data pin input value |

## Verification
Every cycle, the assertions check the following. The driven bit never moves except on an MDC fall. MDC is parked low and rises when the divider says so. Input samples are taken only while the pin is released. A busy-time write leaves the register unchanged, and clearing the enable drops the frame. Only the bench scenarios can show that the bit stream is correct: the preamble, the field order and the turnaround release point. They also show that returned read bits land in order, and they check the exact frame length and the MDC period measured on the pin.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int IDX_W      = 6;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_STAT  = 2'd1,
    SEL_MAINT = 2'd2
  } reg_sel_e;

  localparam int EN_BIT   = 4;
  localparam int IDLE_BIT = 2;

  // Bit driven at serial position idx: preamble ones, then word MSB first.
  function automatic logic frame_bit(input logic [31:0] word,
                                     input logic [IDX_W-1:0] idx);
    if (!idx[5]) return 1'b1;
    return word[5'd31 - idx[4:0]];
  endfunction

  function automatic logic is_read(input logic [31:0] word);
    return word[29:28] == 2'b10;
  endfunction

  // First serial position (frame bit 17) from which a read releases the pin.
  function automatic logic released(input logic [IDX_W-1:0] idx);
    return idx >= 6'd46;
  endfunction

  // Serial positions carrying returned data bits 15..0.
  function automatic logic data_slot(input logic [IDX_W-1:0] idx);
    return idx >= 6'd48;
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap     = (cnt == LAST);
  assign rise_evt = run && wrap && !mdc;
  assign fall_evt = run && wrap && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  p_mdc_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> mdc);
  p_mdc_parked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        abort,
  input  logic [31:0] word,
  input  logic        rise_evt,
  input  logic        fall_evt,
  output logic        busy,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        cap_valid
);
  logic [IDX_W-1:0] idx;
  logic             rd_op;

  assign rd_op     = is_read(word);
  assign mdio_o    = busy ? frame_bit(word, idx) : 1'b0;
  assign mdio_oe   = busy && !(rd_op && released(idx));
  assign cap_valid = busy && rd_op && rise_evt && data_slot(idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy && fall_evt) begin
      if (idx == IDX_W'(FRAME_BITS - 1)) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  p_tx_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && $past(mdio_oe) && !$past(fall_evt)) |-> $stable(mdio_o));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic        ctl_en;
  logic [31:0] maint;
  logic        busy;
  logic        start;
  logic        rise_evt;
  logic        fall_evt;
  logic        cap_valid;
  logic        idle_flag;
  logic        maint_wr;

  assign maint_wr  = reg_wr && (reg_sel == SEL_MAINT);
  assign start     = maint_wr && ctl_en && !busy;
  assign idle_flag = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en <= 1'b0;
      maint  <= '0;
    end else begin
      if (reg_wr && reg_sel == SEL_CTRL) ctl_en <= reg_wdata[EN_BIT];
      if (start)
        maint <= reg_wdata;
      else if (cap_valid)
        maint[15:0] <= {maint[14:0], mdio_i};
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_CTRL:  reg_rdata[EN_BIT]   = ctl_en;
      SEL_STAT:  reg_rdata[IDLE_BIT] = idle_flag;
      SEL_MAINT: reg_rdata           = maint;
      default:   reg_rdata           = '0;
    endcase
  end

  mdio_clkgen #(.CLK_DIV(CLK_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(!ctl_en),
    .word(maint), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .cap_valid(cap_valid)
  );

  p_idle_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !idle_flag);
  p_sample_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |-> !mdio_oe);
  p_busy_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && maint_wr) |=> (maint[31:16] == $past(maint[31:16])));
  p_disable_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> !busy);
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int FRAME_CYC  = 64 * DIV;
  localparam int NV         = 5;
  localparam logic [31:0] VEC_WORD [NV] = '{32'h608A0000, 32'h51821234,
                                           32'h6FFE0000, 32'h60060000,
                                           32'h5292BEEF};
  localparam logic [15:0] VEC_RESP [NV] = '{16'hA5C3, 16'h0F0F, 16'hFFFF,
                                           16'h0000, 16'h3C5A};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  int          rise_cnt = 0;
  logic [63:0] cap_o, cap_oe;
  logic [15:0] phy_resp = '0;
  time         t_rise [2];
  time         t_fall0;
  int          fall_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_master #(.CLK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model: records the pin at each rise, returns data after each fall
  always @(posedge mdc) begin
    if (rise_cnt < 64) begin
      cap_o[63 - rise_cnt]  = mdio_o;
      cap_oe[63 - rise_cnt] = mdio_oe;
      if (rise_cnt < 2) t_rise[rise_cnt] = $time;
    end
    rise_cnt = rise_cnt + 1;
  end
  always @(negedge mdc) begin
    if (fall_cnt == 0) t_fall0 = $time;
    fall_cnt = fall_cnt + 1;
    if (rise_cnt >= 48 && rise_cnt < 64) mdio_i = phy_resp[63 - rise_cnt];
  end

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  // Launches a frame and returns the number of clocks it stays busy.
  task automatic run_frame(input logic [31:0] w, input logic [15:0] resp,
                           output int busy_cyc);
    logic [31:0] s;
    rise_cnt = 0; fall_cnt = 0; phy_resp = resp;
    cap_o = '0; cap_oe = '0;
    wr(2'd2, w);
    busy_cyc = 1;
    reg_sel = 2'd1;
    #1 s = reg_rdata;
    while (!s[2]) begin
      @(negedge clk); #1 s = reg_rdata;
      if (!s[2]) busy_cyc = busy_cyc + 1;
    end
  endtask

  initial begin
    logic [31:0] d;
    int          bc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd1, d); check("R1 idle", 64'(d), 64'h4);
    rd(2'd0, d); check("R1 ctrl", 64'(d), 64'h0);
    rd(2'd2, d); check("R1 maint", 64'(d), 64'h0);
    check("R1 pins", {62'b0, mdc, mdio_oe}, 64'h0);

    // R8 disabled: write ignored
    wr(2'd2, 32'h51821234);
    rd(2'd2, d); check("R8 ignored when disabled", 64'(d), 64'h0);
    rd(2'd1, d); check("R8 no start when disabled", 64'(d), 64'h4);

    wr(2'd0, 32'h10);
    rd(2'd0, d); check("R9 ctrl readback", 64'(d), 64'h10);

    // Vector table: R3, R5, R6
    for (int i = 0; i < NV; i++) begin
      run_frame(VEC_WORD[i], VEC_RESP[i], bc);
      check("R6 frame length", 64'(bc), 64'(FRAME_CYC));
      if (VEC_WORD[i][29:28] == 2'b10) begin
        check("R3 read header", {18'b0, cap_o[63:18]}, {18'b0, 32'hFFFFFFFF, VEC_WORD[i][31:18]});
        check("R5 release", cap_oe, {46'h3FFFFFFFFFFF, 18'h0});
        rd(2'd2, d); check("R5 read data", 64'(d), 64'({VEC_WORD[i][31:16], VEC_RESP[i]}));
      end else begin
        check("R3 write stream", cap_o, {32'hFFFFFFFF, VEC_WORD[i]});
        check("R6 driven", cap_oe, '1);
        rd(2'd2, d); check("R6 word kept", 64'(d), 64'(VEC_WORD[i]));
      end
    end

    // R4 MDC period and duty, measured during the last frame
    check("R4 period", 64'(t_rise[1] - t_rise[0]), 64'(DIV * CLK_PERIOD));
    check("R4 high half", 64'(t_fall0 - t_rise[0]), 64'(DIV * CLK_PERIOD / 2));
    check("R4 parked low", {63'b0, mdc}, 64'h0);

    // R7 write while busy ignored
    rise_cnt = 0; fall_cnt = 0; cap_o = '0; cap_oe = '0;
    wr(2'd2, 32'h51821234);
    repeat (20) @(negedge clk);
    wr(2'd2, 32'h608A0000);
    rd(2'd2, d); check("R7 reg unchanged", 64'(d), 64'h51821234);
    rd(2'd1, d);
    while (!d[2]) rd(2'd1, d);
    check("R7 stream unchanged", cap_o, {32'hFFFFFFFF, 32'h51821234});

    // R8 abort mid-frame
    wr(2'd2, 32'h608A0000);
    repeat (100) @(negedge clk);
    rd(2'd1, d); check("R2 busy flag", 64'(d), 64'h0);
    wr(2'd0, 32'h0);
    repeat (3) @(negedge clk);
    rd(2'd1, d); check("R8 abort idle", 64'(d), 64'h4);
    check("R8 abort pins", {62'b0, mdc, mdio_oe}, 64'h0);

    // R2 idle drops on the clock after launch
    wr(2'd0, 32'h10);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = 32'h5292BEEF;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 2'd1;
    #1 check("R2 idle low next clock", 64'(reg_rdata), 64'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule